// File: doc/BRIEF.md
# Double-Banked Output Gamma Lookup

This block is the last color stage of a pixel pipeline. It remaps each of the three channels of a pixel through a piecewise-linear transfer curve. The curves live in two table banks, A and B. Each bank holds a separate red, green and blue table. The pixel path reads one bank while a host loads a new curve into the other bank, so a curve can be replaced without a visible glitch. The block can also pass pixels through untouched.

The host reaches the block through four word-wide registers selected by a 2-bit address:

| Address | Register | Fields |
|---|---|---|
| 0 | Mode | bits 1:0 mode, bit 4 bank select |
| 1 | Table-write control | bits 2:0 channel write mask, bit 8 target bank |
| 2 | Table index | the low bits give the entry to write next |
| 3 | Table data | the low `DW` bits give the value for the entry |

A new mode and a new bank select are held as pending values. They move into the in-use status outputs only on a frame-start pulse, so a curve swap lands on a frame boundary. A curve of 2^SEG_BITS segments occupies 2^SEG_BITS+1 entries. The last entry is the endpoint of the final segment.

The pixel stream is qualified by a valid bit. Results appear one clock after the input.

Top module: `gamma_pingpong`

## Requirements
- R1: When the in-use mode is 2 the curve is applied. In-use mode 0, and the reserved values 1 and 3, act as bypass: each output channel equals the input channel one cycle later.
- R2: An in-use bank select of 0 makes the pixel path read bank A, and 1 makes it read bank B.
- R3: Bit 8 of the table-write control register picks the bank that table-data writes go to: 0 is bank A and 1 is bank B.
- R4: Bits 2:0 of the table-write control register gate the table-data writes per channel. Bit 2 is red, bit 1 is green and bit 0 is blue. The value 7 writes all three channels with one write.
- R5: A write to the index register sets the entry pointer. Each table-data write stores its value at the pointer in every enabled channel and then increments the pointer. A data write with the pointer past the last entry (2^SEG_BITS) is dropped, and the pointer does not wrap.
- R6: In curve mode, for an input v the segment s is the top SEG_BITS bits of v and f is the remaining DW-SEG_BITS bits. The output is floor((e[s]*(2^F - f) + e[s+1]*f) / 2^F), where F = DW-SEG_BITS and e is that channel's table in the in-use bank.
- R7: Writes to the mode register change `cur_mode` and `cur_sel` only on a cycle with `frame_start` high. At that clock edge they take the last written values, and between pulses they hold.
- R8: Table writes to the bank that is not in use never change the pixel output.
- R9: `out_valid` follows `pix_valid` with one cycle of delay. After reset, `out_valid`, the outputs, `cur_mode` and `cur_sel` are all 0. The pending mode and select are 0, and the write mask resets to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 2 | Host register address |
| host_wdata | input | HW | Host write data |
| frame_start | input | 1 | Frame boundary pulse; loads pending mode and select |
| pix_valid | input | 1 | Input pixel valid |
| pix_r | input | DW | Input red |
| pix_g | input | DW | Input green |
| pix_b | input | DW | Input blue |
| out_valid | output | 1 | Output pixel valid |
| out_r | output | DW | Output red |
| out_g | output | DW | Output green |
| out_b | output | DW | Output blue |
| cur_mode | output | 2 | In-use mode |
| cur_sel | output | 1 | In-use bank select |

## Verification
A corrupted table entry, or a wrong bank or write pointer, shows up at the pixel outputs. It appears one cycle after any input whose segment touches the affected entry. The bench therefore sweeps every input code on all three channels after each table load. A pending-versus-in-use mixup appears at once on `cur_mode` and `cur_sel`. It also appears on the next pixel, which comes from the wrong bank or takes the wrong bypass decision. For this reason the bench probes pixels between a register write and the frame pulse that follows it. Pixel probes interleaved with each write into the idle bank catch any leakage from that bank into the live one.

// File: rtl/gamma_pingpong.sv
module gamma_pingpong #(
  parameter int DW = 8,
  parameter int SEG_BITS = 3,
  parameter int HW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  logic [1:0]    host_addr,
  input  logic [HW-1:0] host_wdata,
  input  logic          frame_start,
  input  logic          pix_valid,
  input  logic [DW-1:0] pix_r,
  input  logic [DW-1:0] pix_g,
  input  logic [DW-1:0] pix_b,
  output logic          out_valid,
  output logic [DW-1:0] out_r,
  output logic [DW-1:0] out_g,
  output logic [DW-1:0] out_b,
  output logic [1:0]    cur_mode,
  output logic          cur_sel
);
  localparam int ENTRIES = (1 << SEG_BITS) + 1;
  localparam int FB = DW - SEG_BITS;
  localparam int IW = $clog2(ENTRIES + 1);
  localparam int TW = DW + FB + 1;
  localparam logic [FB:0] ONE = (FB+1)'(1) << FB;

  logic [DW-1:0] lut [2][3][ENTRIES];
  logic [1:0]    mode_q;
  logic          sel_q, hsel_q;
  logic [2:0]    mask_q;
  logic [IW-1:0] idx_q;
  logic [DW-1:0] pin [3];
  logic [DW-1:0] res [3];
  logic [DW-1:0] pout [3];

  wire data_wr = host_we && host_addr == 2'd3 && idx_q < IW'(ENTRIES);
  wire lut_on  = cur_mode == 2'd2;

  assign pin[0] = pix_r;
  assign pin[1] = pix_g;
  assign pin[2] = pix_b;
  assign out_r = pout[0];
  assign out_g = pout[1];
  assign out_b = pout[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0; sel_q <= 1'b0; hsel_q <= 1'b0; mask_q <= 3'd7;
      idx_q <= '0; cur_mode <= '0; cur_sel <= 1'b0;
      for (int b = 0; b < 2; b++)
        for (int c = 0; c < 3; c++)
          for (int e = 0; e < ENTRIES; e++) lut[b][c][e] <= '0;
    end else begin
      if (frame_start) begin
        cur_mode <= mode_q;
        cur_sel  <= sel_q;
      end
      if (host_we) begin
        case (host_addr)
          2'd0: begin mode_q <= host_wdata[1:0]; sel_q <= host_wdata[4]; end
          2'd1: begin mask_q <= host_wdata[2:0]; hsel_q <= host_wdata[8]; end
          2'd2: idx_q <= host_wdata[IW-1:0];
          default: ;
        endcase
      end
      if (data_wr) begin
        for (int c = 0; c < 3; c++)
          if (mask_q[2-c]) lut[hsel_q][c][idx_q] <= host_wdata[DW-1:0];
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  for (genvar c = 0; c < 3; c++) begin : g_ch
    logic [SEG_BITS-1:0] seg;
    logic [SEG_BITS:0]   seg1;
    logic [FB-1:0]       frac;
    logic [DW-1:0]       e0, e1;
    logic [TW-1:0]       acc;
    assign seg  = pin[c][DW-1:FB];
    assign frac = pin[c][FB-1:0];
    assign seg1 = {1'b0, seg} + 1'b1;
    assign e0   = lut[cur_sel][c][seg];
    assign e1   = lut[cur_sel][c][seg1];
    assign acc  = TW'(e0) * TW'(ONE - {1'b0, frac}) + TW'(e1) * TW'(frac);
    assign res[c] = acc[FB+DW-1:FB];

    always_ff @(posedge clk) begin
      if (!rst_n) pout[c] <= '0;
      else if (pix_valid) pout[c] <= lut_on ? res[c] : pin[c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_valid <= 1'b0;
    else out_valid <= pix_valid;
  end
endmodule

module gamma_pingpong_chk #(
  parameter int DW = 8,
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_start,
  input logic          pix_valid,
  input logic [DW-1:0] pix_r,
  input logic [DW-1:0] pix_g,
  input logic [DW-1:0] pix_b,
  input logic          out_valid,
  input logic [DW-1:0] out_r,
  input logic [DW-1:0] out_g,
  input logic [DW-1:0] out_b,
  input logic [1:0]    cur_mode,
  input logic          cur_sel,
  input logic [1:0]    mode_q,
  input logic          sel_q,
  input logic [IW-1:0] idx_q,
  input logic          data_wr
);
  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n) pix_valid |=> out_valid); // R9
  AST_VALID_FALL: assert property (@(posedge clk) disable iff (!rst_n) !pix_valid |=> !out_valid); // R9
  AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && cur_mode != 2'd2) |=> (out_r == $past(pix_r) && out_g == $past(pix_g) && out_b == $past(pix_b))); // R1
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(cur_mode) && $stable(cur_sel))); // R7
  AST_STATUS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (cur_mode == $past(mode_q) && cur_sel == $past(sel_q))); // R7
  AST_INDEX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> idx_q == IW'($past(idx_q) + 1'b1)); // R5
endmodule

bind gamma_pingpong gamma_pingpong_chk #(.DW(DW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .pix_valid(pix_valid),
  .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b), .out_valid(out_valid),
  .out_r(out_r), .out_g(out_g), .out_b(out_b), .cur_mode(cur_mode),
  .cur_sel(cur_sel), .mode_q(mode_q), .sel_q(sel_q), .idx_q(idx_q),
  .data_wr(data_wr)
);

// File: tb/gamma_pingpong_tb.sv
module gamma_pingpong_tb;
  localparam int DW = 8, SEG_BITS = 3, HW = 16;
  localparam int NE = (1 << SEG_BITS) + 1;
  localparam int F = DW - SEG_BITS;

  logic clk = 0, rst_n = 0, host_we = 0, frame_start = 0, pix_valid = 0;
  logic [1:0] host_addr = 0;
  logic [HW-1:0] host_wdata = 0;
  logic [DW-1:0] pix_r = 0, pix_g = 0, pix_b = 0;
  logic out_valid, cur_sel;
  logic [DW-1:0] out_r, out_g, out_b;
  logic [1:0] cur_mode;

  int checks = 0, fails = 0;
  int m [2][3][NE];
  int b_hsel = 0, b_mask = 7, b_idx = 0, p_mode = 0, p_sel = 0, a_mode = 0, a_sel = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gamma_pingpong #(.DW(DW), .SEG_BITS(SEG_BITS), .HW(HW)) u_dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hw(input int a, input int d);
    @(negedge clk); host_we = 1; host_addr = 2'(a); host_wdata = HW'(d);
    @(negedge clk); host_we = 0;
  endtask

  task automatic set_wctl(input int mask, input int hsel);
    hw(1, (hsel << 8) | mask); b_mask = mask; b_hsel = hsel;
  endtask

  task automatic set_idx(input int i);
    hw(2, i); b_idx = i;
  endtask

  task automatic dwr(input int v);
    hw(3, v);
    if (b_idx < NE) begin
      for (int c = 0; c < 3; c++) if (b_mask[2-c]) m[b_hsel][c][b_idx] = v;
      b_idx++;
    end
  endtask

  task automatic set_mode(input int mode, input int sel);
    hw(0, (sel << 4) | mode); p_mode = mode; p_sel = sel;
  endtask

  task automatic fs();
    @(negedge clk); frame_start = 1;
    @(negedge clk); frame_start = 0;
    a_mode = p_mode; a_sel = p_sel;
  endtask

  function automatic int expv(input int c, input int v);
    int s, f;
    if (a_mode != 2) return v;
    s = v >> F; f = v % (1 << F);
    return (m[a_sel][c][s] * ((1 << F) - f) + m[a_sel][c][s+1] * f) / (1 << F);
  endfunction

  task automatic pix_chk(input int v, input string req);
    int r, g, b, er, eg, eb, bad;
    r = v; g = 255 - v; b = v ^ 8'h5a;
    er = expv(0, r); eg = expv(1, g); eb = expv(2, b);
    @(negedge clk); pix_valid = 1; pix_r = 8'(r); pix_g = 8'(g); pix_b = 8'(b);
    @(negedge clk); pix_valid = 0;
    checks++;
    bad = (out_r != 8'(er)) || (out_g != 8'(eg)) || (out_b != 8'(eb)) || !out_valid;
    if (bad) begin
      fails++;
      $display("FAIL %s in=%0d actual=%0d/%0d/%0d v%0b expected=%0d/%0d/%0d v1",
               req, v, out_r, out_g, out_b, out_valid, er, eg, eb);
    end
  endtask

  task automatic sweep(input string req);
    for (int v = 0; v < 256; v++) pix_chk(v, req);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 2; b++) for (int c = 0; c < 3; c++) for (int e = 0; e < NE; e++) m[b][c][e] = 0;
    repeat (3) @(negedge clk);
    chk("R9 reset out_valid", out_valid, 0);
    chk("R9 reset cur_mode", cur_mode, 0);
    chk("R9 reset cur_sel", cur_sel, 0);
    chk("R9 reset out_r", out_r, 0);
    rst_n = 1;

    sweep("R1 bypass mode 0");
    @(negedge clk); chk("R9 out_valid idle", out_valid, 0);

    // bank A, one channel at a time (R4, R3 target bank A)
    set_wctl(4, 0); set_idx(0); for (int e = 0; e < NE; e++) dwr(e * 31);
    set_wctl(2, 0); set_idx(0); for (int e = 0; e < NE; e++) dwr(255 - e * 30);
    set_wctl(1, 0); set_idx(0); for (int e = 0; e < NE; e++) dwr(e * e * 3);

    set_mode(2, 0);
    chk("R7 mode pending before frame", cur_mode, 0);
    pix_chk(77, "R7 still bypass before frame");
    fs();
    chk("R7 mode after frame", cur_mode, 2);
    sweep("R6 R4 bank A curve");

    // bank B while A live: all-channel mask then green only (R8)
    set_wctl(7, 1); set_idx(0);
    for (int e = 0; e < NE; e++) begin dwr(20 + e * 25); pix_chk(e * 29, "R8 idle B write"); end
    set_wctl(2, 1); set_idx(0);
    for (int e = 0; e < NE; e++) begin dwr(200 - e * 20); pix_chk(e * 31 + 3, "R8 idle B write"); end
    dwr(8'haa); // past end: dropped (R5)
    dwr(8'h55);

    set_mode(2, 1);
    chk("R7 sel pending before frame", cur_sel, 0);
    for (int v = 0; v < 256; v += 17) pix_chk(v, "R7 still bank A");
    fs();
    chk("R7 sel after frame", cur_sel, 1);
    sweep("R2 R5 bank B curve");

    // rewrite A while B live (R8, R3)
    set_wctl(7, 0); set_idx(0);
    for (int e = 0; e < NE; e++) begin dwr(250 - e * 28); pix_chk(e * 28 + 1, "R8 idle A write"); end
    set_mode(2, 0); fs();
    chk("R2 sel back to A", cur_sel, 0);
    sweep("R3 new bank A curve");

    set_mode(1, 0); fs();
    chk("R7 reserved mode 1 visible", cur_mode, 1);
    sweep("R1 reserved mode 1 bypass");
    set_mode(3, 1); fs();
    sweep("R1 reserved mode 3 bypass");
    set_mode(0, 1); fs();
    sweep("R1 mode 0 bypass");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule